// File: doc/BRIEF.md
# SMBus Master Status and Interrupt Unit

This unit keeps the status flags for one SMBus master channel and turns them into two interrupt lines. It watches the bus engine's busy level and its two error pulses (no acknowledge, lost arbitration). When busy drops, it records a completion event. When either error pulse arrives, it records an error event. It also notes whether the error came from lost arbitration.

The two events are cleared in different ways. A completion is cleared as a side effect of reading the status register. An error stays until software writes a one to its bit. A two-bit control register enables each interrupt separately. The enable acts only on the output line and leaves the recorded event untouched.

While the engine is busy, writes to the control and status registers are discarded. The same condition is sent out as a lockout level, so that the channel's other registers can be guarded in the same way. Address decoding is done elsewhere. The unit receives one read strobe and two write strobes that have already been decoded.

Top module: `smbst_top`

## Requirements
- R1: After a synchronous reset, every flag, the control register and both interrupt lines are 0.
- R2: Completion flag `stat_o[1]` is set at the clock edge that ends the first cycle in which `eng_busy_i` is low after having been high in the previous cycle. A busy level that stays low does not set it again.
- R3: A cycle with `stat_rd_i` high clears `stat_o[1]` at that cycle's edge. If a busy fall lands in the same cycle, the flag is set instead.
- R4: A pulse on `eng_nak_i` or `eng_arb_i` sets error flag `stat_o[2]` at the next edge. A pulse on `eng_arb_i` also sets cause bit `stat_o[3]`.
- R5: `stat_o[2]` and `stat_o[3]` are cleared only by a status write whose bit 2 is one. Writing zero to bit 2, or reading status, leaves them set. If an error pulse arrives in the same cycle as the clearing write, the error flag stays set and the cause bit is not cleared.
- R6: `irq_done_o` equals `stat_o[1]` AND control bit 0, and `irq_err_o` equals `stat_o[2]` AND control bit 1, in the same cycle. Disabling an interrupt leaves its flag unchanged, so enabling it later raises the line at once.
- R7: A control or status write made in a cycle where `eng_busy_i` is high is dropped. `wr_lock_o` follows `eng_busy_i`.
- R8: `stat_o[0]` shows the live `eng_busy_i` level. The status bits above 3 and the control bits above 1 read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| eng_busy_i | input | 1 | Engine transfer-in-progress level |
| eng_nak_i | input | 1 | Engine pulse: acknowledge missing |
| eng_arb_i | input | 1 | Engine pulse: arbitration lost, retries used up |
| stat_rd_i | input | 1 | Status register read strobe |
| stat_wr_i | input | 1 | Status register write strobe |
| ctrl_wr_i | input | 1 | Control register write strobe |
| wr_data_i | input | REG_W | Write data |
| stat_o | output | REG_W | Status read value |
| ctrl_o | output | REG_W | Control read value |
| irq_done_o | output | 1 | Completion interrupt |
| irq_err_o | output | 1 | Error interrupt |
| wr_lock_o | output | 1 | Register write lockout |

## Verification
A reference model is stepped once per cycle. It is driven with three kinds of stimulus:
- Busy runs that end in a fall, compared against long low stretches. This separates edge detection from level detection.
- Status reads at three points: alone, in the same cycle as a busy fall, and while an error is pending. This shows that a read clears only the completion flag and that a new completion beats a clear.
- Error pulses against status writes carrying zero and one in bit 2, including a write that lands on a pulse. This shows the write-one-to-clear behaviour and its set priority.

Mask toggles made while a flag is pending show that enabling an interrupt acts only on the output line. Writes issued during busy show that the lockout drops them.

// File: rtl/smbst_pkg.sv
package smbst_pkg;

    localparam int ST_BUSY = 0;
    localparam int ST_DONE = 1;
    localparam int ST_ERR  = 2;
    localparam int ST_ARB  = 3;
    localparam int STAT_W  = 4;

    localparam int CT_DONE_EN = 0;
    localparam int CT_ERR_EN  = 1;
    localparam int CTRL_W     = 2;

    localparam int F_DONE = 0;
    localparam int F_ERR  = 1;
    localparam int F_ARB  = 2;
    localparam int NFLAG  = 3;

    localparam int NIRQ = 2;

    typedef struct packed {
        logic arb;
        logic err;
        logic done;
        logic busy;
    } stat_t;

    typedef struct packed {
        logic err_en;
        logic done_en;
    } ctrl_t;

    function automatic logic sticky_next(logic cur, logic set, logic clr);
        return set | (cur & ~clr);
    endfunction

    function automatic logic [STAT_W-1:0] pack_stat(stat_t s);
        return {s.arb, s.err, s.done, s.busy};
    endfunction

endpackage

// File: rtl/smbst_busy_mon.sv
module smbst_busy_mon (
    input  logic clk,
    input  logic rst,
    input  logic busy_i,
    output logic fall_o
);
    logic busy_q;

    always_ff @(posedge clk) begin
        if (rst) busy_q <= 1'b0;
        else     busy_q <= busy_i;
    end

    assign fall_o = busy_q & ~busy_i;
endmodule

// File: rtl/smbst_flags.sv
module smbst_flags #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] flag_o
);
    import smbst_pkg::*;

    for (genvar g = 0; g < N; g++) begin : g_flag
        logic q;
        always_ff @(posedge clk) begin
            if (rst) q <= 1'b0;
            else     q <= sticky_next(q, set_i[g], clr_i[g]);
        end
        assign flag_o[g] = q;
    end
endmodule

// File: rtl/smbst_ctrl_reg.sv
module smbst_ctrl_reg #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_i,
    input  logic         lock_i,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] q;

    always_ff @(posedge clk) begin
        if (rst)                 q <= '0;
        else if (wr_i && !lock_i) q <= d_i;
    end

    assign q_o = q;
endmodule

// File: rtl/smbst_irq_gate.sv
module smbst_irq_gate #(
    parameter int N = 2
) (
    input  logic [N-1:0] pend_i,
    input  logic [N-1:0] en_i,
    output logic [N-1:0] irq_o
);
    for (genvar g = 0; g < N; g++) begin : g_irq
        assign irq_o[g] = pend_i[g] & en_i[g];
    end
endmodule

// File: rtl/smbst_top.sv
module smbst_top #(
    parameter int REG_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             eng_busy_i,
    input  logic             eng_nak_i,
    input  logic             eng_arb_i,
    input  logic             stat_rd_i,
    input  logic             stat_wr_i,
    input  logic             ctrl_wr_i,
    input  logic [REG_W-1:0] wr_data_i,
    output logic [REG_W-1:0] stat_o,
    output logic [REG_W-1:0] ctrl_o,
    output logic             irq_done_o,
    output logic             irq_err_o,
    output logic             wr_lock_o
);
    import smbst_pkg::*;

    localparam int PAD_S = REG_W - STAT_W;
    localparam int PAD_C = REG_W - CTRL_W;

    logic             lock;
    logic             fall;
    logic             err_evt;
    logic             w1c_err;
    logic [NFLAG-1:0] f_set, f_clr, flags;
    logic [CTRL_W-1:0] ctrl_bits;
    ctrl_t            ctrl;
    stat_t            stat;
    logic [NIRQ-1:0]  pend, en, irq;
    logic             unused_wr_hi;

    // Writes are locked out for the whole time the engine is busy (R7)
    assign lock      = eng_busy_i;
    assign wr_lock_o = lock;

    smbst_busy_mon u_busy (
        .clk    (clk),
        .rst    (rst),
        .busy_i (eng_busy_i),
        .fall_o (fall)
    );

    assign err_evt = eng_nak_i | eng_arb_i;
    assign w1c_err = stat_wr_i & wr_data_i[ST_ERR] & ~lock;

    // set wins over clear inside each flag (R3, R5)
    always_comb begin
        f_set         = '0;
        f_clr         = '0;
        f_set[F_DONE] = fall;
        f_clr[F_DONE] = stat_rd_i;
        f_set[F_ERR]  = err_evt;
        f_clr[F_ERR]  = w1c_err;
        f_set[F_ARB]  = eng_arb_i;
        f_clr[F_ARB]  = w1c_err & ~err_evt;
    end

    smbst_flags #(.N(NFLAG)) u_flags (
        .clk    (clk),
        .rst    (rst),
        .set_i  (f_set),
        .clr_i  (f_clr),
        .flag_o (flags)
    );

    smbst_ctrl_reg #(.W(CTRL_W)) u_ctrl (
        .clk    (clk),
        .rst    (rst),
        .wr_i   (ctrl_wr_i),
        .lock_i (lock),
        .d_i    (wr_data_i[CTRL_W-1:0]),
        .q_o    (ctrl_bits)
    );

    assign ctrl = ctrl_t'(ctrl_bits);

    assign pend = {flags[F_ERR], flags[F_DONE]};
    assign en   = {ctrl.err_en, ctrl.done_en};

    smbst_irq_gate #(.N(NIRQ)) u_irq (
        .pend_i (pend),
        .en_i   (en),
        .irq_o  (irq)
    );

    assign irq_done_o = irq[0];
    assign irq_err_o  = irq[1];

    always_comb begin
        stat.busy = eng_busy_i;
        stat.done = flags[F_DONE];
        stat.err  = flags[F_ERR];
        stat.arb  = flags[F_ARB];
    end

    assign stat_o = {{PAD_S{1'b0}}, pack_stat(stat)};
    assign ctrl_o = {{PAD_C{1'b0}}, ctrl_bits};

    assign unused_wr_hi = ^wr_data_i[REG_W-1:STAT_W] ^ wr_data_i[ST_ARB];
endmodule

// File: rtl/smbst_chk.sv
module smbst_chk #(
    parameter int REG_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             eng_busy_i,
    input logic             eng_nak_i,
    input logic             eng_arb_i,
    input logic             stat_rd_i,
    input logic             stat_wr_i,
    input logic             ctrl_wr_i,
    input logic [REG_W-1:0] wr_data_i,
    input logic [REG_W-1:0] stat_o,
    input logic [REG_W-1:0] ctrl_o,
    input logic             irq_done_o,
    input logic             irq_err_o,
    input logic             wr_lock_o
);
    p_done_on_fall_r2: assert property (@(posedge clk) disable iff (rst)
        (!eng_busy_i && $past(eng_busy_i)) |=> stat_o[1]);

    p_done_needs_fall_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(stat_o[1]) |-> (!$past(eng_busy_i) && $past(eng_busy_i, 2)));

    p_read_clears_r3: assert property (@(posedge clk) disable iff (rst)
        (stat_rd_i && !(!eng_busy_i && $past(eng_busy_i))) |=> !stat_o[1]);

    p_err_sets_r4: assert property (@(posedge clk) disable iff (rst)
        (eng_nak_i || eng_arb_i) |=> stat_o[2]);

    p_err_sticky_r5: assert property (@(posedge clk) disable iff (rst)
        (stat_o[2] && !(stat_wr_i && wr_data_i[2] && !eng_busy_i)) |=> stat_o[2]);

    p_done_mask_r6: assert property (@(posedge clk) disable iff (rst)
        !ctrl_o[0] |-> !irq_done_o);

    p_err_mask_r6: assert property (@(posedge clk) disable iff (rst)
        !ctrl_o[1] |-> !irq_err_o);

    p_ctrl_locked_r7: assert property (@(posedge clk) disable iff (rst)
        (wr_lock_o && ctrl_wr_i) |=> $stable(ctrl_o));
endmodule

bind smbst_top smbst_chk #(.REG_W(REG_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .eng_busy_i (eng_busy_i),
    .eng_nak_i  (eng_nak_i),
    .eng_arb_i  (eng_arb_i),
    .stat_rd_i  (stat_rd_i),
    .stat_wr_i  (stat_wr_i),
    .ctrl_wr_i  (ctrl_wr_i),
    .wr_data_i  (wr_data_i),
    .stat_o     (stat_o),
    .ctrl_o     (ctrl_o),
    .irq_done_o (irq_done_o),
    .irq_err_o  (irq_err_o),
    .wr_lock_o  (wr_lock_o)
);

// File: tb/tb_smbst_top.sv
module tb_smbst_top;
    localparam int REG_W = 8;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             eng_busy_i = 1'b0, eng_nak_i = 1'b0, eng_arb_i = 1'b0;
    logic             stat_rd_i = 1'b0, stat_wr_i = 1'b0, ctrl_wr_i = 1'b0;
    logic [REG_W-1:0] wr_data_i = '0;
    logic [REG_W-1:0] stat_o, ctrl_o;
    logic             irq_done_o, irq_err_o, wr_lock_o;

    always #2 clk = ~clk;

    smbst_top #(.REG_W(REG_W)) dut (.*);

    int n_chk = 0, n_bad = 0;
    bit done_run = 1'b0;

    // model state, built from the requirements
    logic m_prev = 1'b0, m_done = 1'b0, m_err = 1'b0, m_arb = 1'b0;
    logic [1:0] m_ctrl = 2'b00;

    // expected word: {lock, irq_err, irq_done, ctrl[7:0], stat[7:0]}
    logic [18:0] exp_q[$];
    string       tag_q[$];

    always @(posedge clk) begin
        #1;
        while (exp_q.size() > 0) begin
            logic [18:0] e;
            logic [18:0] a;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            a = {wr_lock_o, irq_err_o, irq_done_o, ctrl_o, stat_o};
            n_chk++;
            if (a !== e) begin
                n_bad++;
                $display("FAIL %s: actual %h expected %h", t, a, e);
            end
        end
    end

    task automatic cyc(input string tag, input logic b, input logic nak, input logic arb,
                       input logic rd, input logic swr, input logic cwr, input logic [7:0] d);
        logic fall, eset, w1c;
        @(negedge clk);
        eng_busy_i = b; eng_nak_i = nak; eng_arb_i = arb;
        stat_rd_i = rd; stat_wr_i = swr; ctrl_wr_i = cwr; wr_data_i = d;
        @(posedge clk);
        fall = m_prev & ~b;
        eset = nak | arb;
        w1c  = swr & d[2] & ~b;
        m_done = fall ? 1'b1 : (rd ? 1'b0 : m_done);
        m_arb  = arb ? 1'b1 : ((w1c && !eset) ? 1'b0 : m_arb);
        m_err  = eset ? 1'b1 : (w1c ? 1'b0 : m_err);
        if (cwr && !b) m_ctrl = d[1:0];
        m_prev = b;
        exp_q.push_back({b, m_err & m_ctrl[1], m_done & m_ctrl[0], 6'b0, m_ctrl,
                         4'b0, m_arb, m_err, m_done, b});
        tag_q.push_back(tag);
    endtask

    task automatic idle(input string tag);
        cyc(tag, 0, 0, 0, 0, 0, 0, 8'h00);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        idle("R1 reset state");
        // R2: busy run then fall; steady low afterwards
        cyc("R8 busy visible", 1, 0, 0, 0, 0, 0, 8'h00);
        cyc("R2 busy held", 1, 0, 0, 0, 0, 0, 8'h00);
        idle("R2 fall sets done");
        idle("R2 done held");
        cyc("R3 read clears done", 0, 0, 0, 1, 0, 0, 8'h00);
        idle("R2 steady low no set");
        idle("R2 steady low no set again");
        // R3: read in fall cycle
        cyc("R2 busy", 1, 0, 0, 0, 0, 0, 8'h00);
        cyc("R3 fall beats read", 0, 0, 0, 1, 0, 0, 8'h00);
        idle("R3 done remains");
        // R6: enable done irq, mask / unmask
        cyc("R6 enable done irq", 0, 0, 0, 0, 0, 1, 8'h01);
        cyc("R6 mask keeps flag", 0, 0, 0, 0, 0, 1, 8'h00);
        cyc("R6 unmask raises at once", 0, 0, 0, 0, 0, 1, 8'hFF);
        cyc("R3 read clears irq", 0, 0, 0, 1, 0, 0, 8'h00);
        // R4: nak pulse then clear
        cyc("R4 nak sets err", 0, 1, 0, 0, 0, 0, 8'h00);
        cyc("R5 write zero keeps err", 0, 0, 0, 0, 1, 0, 8'hFB);
        cyc("R5 read keeps err", 0, 0, 0, 1, 0, 0, 8'h00);
        cyc("R6 mask err irq", 0, 0, 0, 0, 0, 1, 8'h01);
        cyc("R6 unmask err irq", 0, 0, 0, 0, 0, 1, 8'h03);
        cyc("R5 write one clears err", 0, 0, 0, 0, 1, 0, 8'h04);
        idle("R5 err stays clear");
        // R4: arb pulse sets cause
        cyc("R4 arb sets err and cause", 0, 0, 1, 0, 0, 0, 8'h00);
        cyc("R5 nak with clear keeps all", 0, 1, 0, 0, 1, 0, 8'h04);
        cyc("R5 clear both", 0, 0, 0, 0, 1, 0, 8'h04);
        cyc("R5 arb with clear sets", 0, 0, 1, 0, 1, 0, 8'h04);
        cyc("R5 clear again", 0, 0, 0, 0, 1, 0, 8'h04);
        // R7: writes during busy are dropped
        cyc("R7 busy start", 1, 0, 0, 0, 0, 0, 8'h00);
        cyc("R7 ctrl write dropped", 1, 0, 0, 0, 0, 1, 8'h00);
        cyc("R7 err set while busy", 1, 0, 1, 0, 0, 0, 8'h00);
        cyc("R7 w1c dropped while busy", 1, 0, 0, 0, 1, 0, 8'h04);
        cyc("R2 fall with err pending", 0, 0, 0, 0, 0, 0, 8'h00);
        cyc("R7 w1c after busy", 0, 0, 0, 0, 1, 0, 8'h04);
        cyc("R8 ctrl upper bits zero", 0, 0, 0, 0, 0, 1, 8'hFC);
        // R1: reset mid-state
        cyc("R4 nak before reset", 0, 1, 0, 0, 0, 1, 8'h03);
        @(negedge clk);
        rst = 1'b1;
        eng_nak_i = 1'b0; ctrl_wr_i = 1'b0;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        m_prev = 0; m_done = 0; m_err = 0; m_arb = 0; m_ctrl = 2'b00;
        idle("R1 reset clears all");
        repeat (2) @(posedge clk);
        #2;
        done_run = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #200000;
        if (!done_run) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule